// File: doc/BRIEF.md
# I2C Master Status and Interrupt Flag Register

This block holds the sixteen-bit status word of an I2C master controller. The bus engine feeds it single-cycle event pulses (START or repeated START, STOP, byte received, byte shifted out with its acknowledge taken, acknowledge slot sampled, timeout, clock-stretch request) and two live levels (SCL and controller activity). A CPU-side port supplies a write enable with write data and a read strobe for the receive buffer. The block returns the status word, a registered interrupt request, and an SCL hold-low request that implements clock stretching.

Ownership differs per flag. Software clears a flag by writing 0 to it. Some flags also accept a written 1, which forces an interrupt. Some can only be set by hardware. The receive-overrun flag is cleared only by reading the buffer. Three small state machines carry the sequential parts:

- **Bus tracker.** States are BUS_FREE and BUS_HELD. The *claim* transition, on START while enabled, goes from BUS_FREE to BUS_HELD. The *release* transition, on STOP or on disable, goes from BUS_HELD to BUS_FREE.
- **Receive-buffer tracker.** States are RXB_EMPTY and RXB_FULL. The *fill* transition, on a received byte, goes from RXB_EMPTY to RXB_FULL. The *drain* transition, on a buffer read with no new byte, goes from RXB_FULL to RXB_EMPTY. A byte arriving while in RXB_FULL without a read signals overrun.
- **Stretch controller.** States are STR_RUN and STR_HOLD. The *grab* transition, on a stretch request while stretching is enabled, goes from STR_RUN to STR_HOLD. The *let-go* transition, on a software write of 0 to the stretch bit, goes from STR_HOLD to STR_RUN.

Top module: `i2cm_status_flags`

## Requirements
- R1: After reset every status bit, `irq` and `scl_hold_low` are 0.
- R2: Bit 15 (bus busy) becomes 1 one cycle after `ev_start` while `ctrl_en` is 1 and becomes 0 one cycle after `ev_stop`. It reads 0 in the same cycle that `ctrl_en` is 0, and `ev_start` is ignored while `ctrl_en` is 0. Writes do not affect it.
- R3: Bit 14 equals `ctrl_active` and bit 10 equals `scl_level` in the same cycle. Writes do not affect them.
- R4: Bits 0 (START seen), 1 (byte sent with acknowledge taken), 4 (timeout) and 11 (STOP seen) are set one cycle after `ev_start`, `ev_tx_done`, `ev_timeout` and `ev_stop` respectively. A write of 0 to one of these bits clears it, and a write of 1 sets it.
- R5: Bit 2 (byte received) is set one cycle after `ev_rx_byte`. A write of 0 clears it, and a write of 1 has no effect.
- R6: On `ev_ack_slot`, bit 7 is loaded with `ack_nack`, where 1 means NACK and 0 means ACK. A write of 0 clears it, and a write of 1 has no effect.
- R7: Bit 9 (overrun) is set when `ev_rx_byte` arrives a second time with no `rd_buf` since the previous byte. A `rd_buf` in the same cycle as the new byte prevents this. `rd_buf` clears bit 9, and a write of 1 sets it. A write of 0 has no effect.
- R8: `ev_stretch` while `stretch_en` is 1 sets bit 3 and drives `scl_hold_low` high. Both stay high until a write of 0 to bit 3. `ev_stretch` with `stretch_en` at 0 and writes of 1 to bit 3 have no effect.
- R9: A hardware set event in the same cycle as a software write of 0 to that bit leaves the bit set.
- R10: Bits 13, 12, 8, 6 and 5 always read 0, whatever is written.
- R11: `irq` is 1 exactly when, in the previous cycle, any status bit was 1 with the matching `irq_en` bit also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable |
| ev_start | input | 1 | START or repeated START detected (pulse) |
| ev_stop | input | 1 | STOP detected (pulse) |
| ev_rx_byte | input | 1 | Byte received into the buffer (pulse) |
| ev_tx_done | input | 1 | Address or data byte sent and acknowledge taken (pulse) |
| ev_ack_slot | input | 1 | Acknowledge slot sampled (pulse) |
| ack_nack | input | 1 | Acknowledge value at `ev_ack_slot`: 1 NACK, 0 ACK |
| ev_timeout | input | 1 | START/STOP failure or SCL low too long (pulse) |
| ev_stretch | input | 1 | Request to hold SCL low (pulse) |
| stretch_en | input | 1 | Clock stretching enabled |
| scl_level | input | 1 | Live SCL level |
| ctrl_active | input | 1 | Controller taking part in a transaction |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 16 | Status register write data |
| rd_buf | input | 1 | Receive buffer read strobe |
| irq_en | input | 16 | Per-bit interrupt enable |
| status | output | 16 | Status word |
| irq | output | 1 | Registered interrupt request |
| scl_hold_low | output | 1 | Request to hold SCL low |

## Verification
If the receive-buffer tracker is in the wrong state, the error appears on bit 9. It shows up either one cycle after the next received byte, or it never shows up when it should. Because of this, the bench reaches each tracker state through a full and a drained buffer before sending the decisive byte. An error in the stretch controller or the bus tracker appears on `scl_hold_low`, bit 3 or bit 15 on the cycle after the event. Enable-forced clearing of bit 15 is visible in the same cycle. A wrong flag or priority rule appears on `status` one cycle after the stimulus and on `irq` one cycle later, so each check samples at those two points.

// File: rtl/i2cm_stat_pkg.sv
package i2cm_stat_pkg;

    localparam int STAT_W = 16;

    // Bit positions inside the status word
    localparam int B_SRI = 0;
    localparam int B_TXI = 1;
    localparam int B_RXI = 2;
    localparam int B_STR = 3;
    localparam int B_TOI = 4;
    localparam int B_NAK = 7;
    localparam int B_ROV = 9;
    localparam int B_SCL = 10;
    localparam int B_SPI = 11;
    localparam int B_ACT = 14;
    localparam int B_BUS = 15;

    localparam logic [STAT_W-1:0] RSV_MASK = 16'h3160;

    // Generic flag slots (register cells built by generate)
    localparam int FLAG_N = 7;
    localparam int S_SRI  = 0;
    localparam int S_TXI  = 1;
    localparam int S_RXI  = 2;
    localparam int S_TOI  = 3;
    localparam int S_NAK  = 4;
    localparam int S_ROV  = 5;
    localparam int S_SPI  = 6;

    typedef enum logic [1:0] {
        FK_SWRW  = 2'd0,   // software may set and clear
        FK_SWCLR = 2'd1,   // software may clear only
        FK_SWSET = 2'd2    // software may set only
    } flag_kind_e;

    typedef enum logic { BUS_FREE, BUS_HELD } bus_state_e;
    typedef enum logic { RXB_EMPTY, RXB_FULL } rxb_state_e;
    typedef enum logic { STR_RUN, STR_HOLD } str_state_e;

    function automatic int slot_pos(input int k);
        case (k)
            S_SRI:   return B_SRI;
            S_TXI:   return B_TXI;
            S_RXI:   return B_RXI;
            S_TOI:   return B_TOI;
            S_NAK:   return B_NAK;
            S_ROV:   return B_ROV;
            default: return B_SPI;
        endcase
    endfunction

    function automatic flag_kind_e slot_kind(input int k);
        case (k)
            S_RXI, S_NAK: return FK_SWCLR;
            S_ROV:        return FK_SWSET;
            default:      return FK_SWRW;
        endcase
    endfunction

endpackage

// File: rtl/i2cm_flag_cell.sv
module i2cm_flag_cell #(
    parameter bit SW_SET_OK = 1'b1,
    parameter bit SW_CLR_OK = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic sw_we,
    input  logic sw_bit,
    output logic q
);

    // Priority: hardware set, hardware clear, software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (hw_set) begin
            q <= 1'b1;
        end else if (hw_clr) begin
            q <= 1'b0;
        end else if (sw_we && sw_bit && SW_SET_OK) begin
            q <= 1'b1;
        end else if (sw_we && !sw_bit && SW_CLR_OK) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cm_bus_tracker.sv
module i2cm_bus_tracker
    import i2cm_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_en,
    input  logic ev_start,
    input  logic ev_stop,
    output logic bus_busy
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_FREE: if (ctrl_en && ev_start && !ev_stop) state_d = BUS_HELD;  // claim
            BUS_HELD: if (!ctrl_en || ev_stop)             state_d = BUS_FREE;  // release
        endcase
    end

    always_comb begin
        bus_busy = (state_q == BUS_HELD) && ctrl_en;
    end

endmodule

// File: rtl/i2cm_rx_tracker.sv
module i2cm_rx_tracker
    import i2cm_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_in,
    input  logic buf_read,
    output logic overrun_evt
);

    rxb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RXB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXB_EMPTY: if (byte_in)              state_d = RXB_FULL;   // fill
            RXB_FULL:  if (buf_read && !byte_in) state_d = RXB_EMPTY;  // drain
        endcase
    end

    always_comb begin
        overrun_evt = (state_q == RXB_FULL) && byte_in && !buf_read;
    end

endmodule

// File: rtl/i2cm_stretch_ctl.sv
module i2cm_stretch_ctl
    import i2cm_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grab_req,
    input  logic sw_release,
    output logic holding
);

    str_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STR_RUN:  if (grab_req)                state_d = STR_HOLD;  // grab
            STR_HOLD: if (sw_release && !grab_req) state_d = STR_RUN;   // let-go
        endcase
    end

    always_comb begin
        holding = (state_q == STR_HOLD);
    end

endmodule

// File: rtl/i2cm_status_flags.sv
module i2cm_status_flags
    import i2cm_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_rx_byte,
    input  logic              ev_tx_done,
    input  logic              ev_ack_slot,
    input  logic              ack_nack,
    input  logic              ev_timeout,
    input  logic              ev_stretch,
    input  logic              stretch_en,
    input  logic              scl_level,
    input  logic              ctrl_active,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              rd_buf,
    input  logic [STAT_W-1:0] irq_en,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              scl_hold_low
);

    logic              bus_busy;
    logic              rx_overrun;
    logic              stretch_hold;
    logic [FLAG_N-1:0] slot_set;
    logic [FLAG_N-1:0] slot_clr;
    logic [FLAG_N-1:0] slot_wbit;
    logic [FLAG_N-1:0] slot_q;
    logic [STAT_W-1:0] status_c;
    logic              irq_q;

    i2cm_bus_tracker u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_en  (ctrl_en),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .bus_busy (bus_busy)
    );

    i2cm_rx_tracker u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_in     (ev_rx_byte),
        .buf_read    (rd_buf),
        .overrun_evt (rx_overrun)
    );

    i2cm_stretch_ctl u_str (
        .clk        (clk),
        .rst_n      (rst_n),
        .grab_req   (ev_stretch && stretch_en),
        .sw_release (wr_en && !wr_data[B_STR]),
        .holding    (stretch_hold)
    );

    // Hardware set and clear events per flag slot
    always_comb begin
        slot_set        = '0;
        slot_clr        = '0;
        slot_set[S_SRI] = ev_start;
        slot_set[S_TXI] = ev_tx_done;
        slot_set[S_RXI] = ev_rx_byte;
        slot_set[S_TOI] = ev_timeout;
        slot_set[S_NAK] = ev_ack_slot && ack_nack;
        slot_clr[S_NAK] = ev_ack_slot && !ack_nack;
        slot_set[S_ROV] = rx_overrun;
        slot_clr[S_ROV] = rd_buf;
        slot_set[S_SPI] = ev_stop;
    end

    always_comb begin
        for (int k = 0; k < FLAG_N; k++) begin
            slot_wbit[k] = wr_data[slot_pos(k)];
        end
    end

    for (genvar k = 0; k < FLAG_N; k++) begin : g_slot
        localparam flag_kind_e KIND = slot_kind(k);
        i2cm_flag_cell #(
            .SW_SET_OK (KIND == FK_SWRW || KIND == FK_SWSET),
            .SW_CLR_OK (KIND == FK_SWRW || KIND == FK_SWCLR)
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (slot_set[k]),
            .hw_clr (slot_clr[k]),
            .sw_we  (wr_en),
            .sw_bit (slot_wbit[k]),
            .q      (slot_q[k])
        );
    end

    // Status word assembly
    always_comb begin
        status_c = '0;
        for (int k = 0; k < FLAG_N; k++) begin
            status_c[slot_pos(k)] = slot_q[k];
        end
        status_c[B_STR] = stretch_hold;
        status_c[B_SCL] = scl_level;
        status_c[B_ACT] = ctrl_active;
        status_c[B_BUS] = bus_busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_c & irq_en);
    end

    always_comb begin
        status       = status_c;
        irq          = irq_q;
        scl_hold_low = stretch_hold;
    end

endmodule

// File: rtl/i2cm_status_flags_chk.sv
module i2cm_status_flags_chk
    import i2cm_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_en,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              ev_rx_byte,
    input logic              ev_ack_slot,
    input logic              ack_nack,
    input logic              ev_timeout,
    input logic              ev_stretch,
    input logic              stretch_en,
    input logic              scl_level,
    input logic              ctrl_active,
    input logic              wr_en,
    input logic [STAT_W-1:0] wr_data,
    input logic              rd_buf,
    input logic [STAT_W-1:0] irq_en,
    input logic [STAT_W-1:0] status,
    input logic              irq,
    input logic              scl_hold_low
);

    assert_bus_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !status[B_BUS]);

    assert_bus_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && ev_start && !ev_stop) |=> (status[B_BUS] || !ctrl_en));

    assert_live_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_SCL] == scl_level) && (status[B_ACT] == ctrl_active));

    assert_start_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> status[B_SRI]);

    assert_rx_hw_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[B_RXI] && !ev_rx_byte) |=> !status[B_RXI]);

    assert_ack_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ack_slot |=> (status[B_NAK] == $past(ack_nack)));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_buf |=> !status[B_ROV]);

    assert_hold_grab_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_en && ev_stretch) |=> (scl_hold_low && status[B_STR]));

    assert_hold_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold_low && !(wr_en && !wr_data[B_STR])) |=> scl_hold_low);

    assert_hw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_timeout |=> status[B_TOI]);

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (|wr_data)) |=> ((status & RSV_MASK) == '0));

    assert_irq_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & irq_en))));

endmodule

bind i2cm_status_flags i2cm_status_flags_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_en      (ctrl_en),
    .ev_start     (ev_start),
    .ev_stop      (ev_stop),
    .ev_rx_byte   (ev_rx_byte),
    .ev_ack_slot  (ev_ack_slot),
    .ack_nack     (ack_nack),
    .ev_timeout   (ev_timeout),
    .ev_stretch   (ev_stretch),
    .stretch_en   (stretch_en),
    .scl_level    (scl_level),
    .ctrl_active  (ctrl_active),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_buf       (rd_buf),
    .irq_en       (irq_en),
    .status       (status),
    .irq          (irq),
    .scl_hold_low (scl_hold_low)
);

// File: tb/test_i2cm_status_flags.sv
module test_i2cm_status_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b0;
    logic        ev_start = 1'b0;
    logic        ev_stop = 1'b0;
    logic        ev_rx_byte = 1'b0;
    logic        ev_tx_done = 1'b0;
    logic        ev_ack_slot = 1'b0;
    logic        ack_nack = 1'b0;
    logic        ev_timeout = 1'b0;
    logic        ev_stretch = 1'b0;
    logic        stretch_en = 1'b0;
    logic        scl_level = 1'b0;
    logic        ctrl_active = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        rd_buf = 1'b0;
    logic [15:0] irq_en = 16'h0;
    logic [15:0] status;
    logic        irq;
    logic        scl_hold_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2cm_status_flags i_i2cm_status_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_en      (ctrl_en),
        .ev_start     (ev_start),
        .ev_stop      (ev_stop),
        .ev_rx_byte   (ev_rx_byte),
        .ev_tx_done   (ev_tx_done),
        .ev_ack_slot  (ev_ack_slot),
        .ack_nack     (ack_nack),
        .ev_timeout   (ev_timeout),
        .ev_stretch   (ev_stretch),
        .stretch_en   (stretch_en),
        .scl_level    (scl_level),
        .ctrl_active  (ctrl_active),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_buf       (rd_buf),
        .irq_en       (irq_en),
        .status       (status),
        .irq          (irq),
        .scl_hold_low (scl_hold_low)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [15:0] d, input bit rd = 1'b0);
        wr_en = 1'b1; wr_data = d; rd_buf = rd;
        step();
        wr_en = 1'b0; wr_data = 16'h0; rd_buf = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 status", status, 16'h0000);
        check("R1 irq", {15'h0, irq}, 16'h0);
        check("R1 hold", {15'h0, scl_hold_low}, 16'h0);
    endtask

    task automatic t_bus();
        ctrl_en = 1'b1;
        ev_start = 1'b1; step(); ev_start = 1'b0;
        check("R2 claim", status, 16'h8001);
        ctrl_en = 1'b0; #1;
        check("R2 disable", status & 16'h8000, 16'h0000);
        step(); ctrl_en = 1'b1; #1;
        check("R2 released", status & 16'h8000, 16'h0000);
        ctrl_en = 1'b0; ev_start = 1'b1; step(); ev_start = 1'b0;
        ctrl_en = 1'b1; #1;
        check("R2 start ignored when off", status & 16'h8000, 16'h0000);
        ev_start = 1'b1; step(); ev_start = 1'b0;
        sw_write(16'h0000);
        check("R2 R4 write 0 keeps busy clears start", status, 16'h8000);
        ev_stop = 1'b1; step(); ev_stop = 1'b0;
        check("R2 R4 stop", status, 16'h0800);
        sw_write(16'h0000);
        check("R4 clear stop", status, 16'h0000);
    endtask

    task automatic t_live();
        scl_level = 1'b1; ctrl_active = 1'b1; #1;
        check("R3 live high", status, 16'h4400);
        sw_write(16'h0000);
        check("R3 write ignored", status, 16'h4400);
        scl_level = 1'b0; ctrl_active = 1'b0; #1;
        check("R3 live low", status, 16'h0000);
    endtask

    task automatic t_sw_set();
        sw_write(16'hFFFF);
        check("R4 R5 R6 R7 R8 R10 write ones", status, 16'h0A13);
        check("R8 hold not forced", {15'h0, scl_hold_low}, 16'h0);
        sw_write(16'h0000, 1'b1);
        check("R4 R7 clear all", status, 16'h0000);
    endtask

    task automatic t_hw_flags();
        ev_tx_done = 1'b1; ev_timeout = 1'b1; ev_rx_byte = 1'b1;
        step();
        ev_tx_done = 1'b0; ev_timeout = 1'b0; ev_rx_byte = 1'b0;
        check("R4 R5 hw events", status, 16'h0016);
        sw_write(16'h0016);
        check("R4 R5 write ones keep", status, 16'h0016);
        sw_write(16'h0012);
        check("R5 write 0 clears rx", status, 16'h0012);
        sw_write(16'h0000, 1'b1);
        check("R4 clear", status, 16'h0000);
        sw_write(16'h0004);
        check("R5 write 1 ignored", status, 16'h0000);
    endtask

    task automatic t_nack();
        ev_ack_slot = 1'b1; ack_nack = 1'b1; step(); ev_ack_slot = 1'b0;
        check("R6 nack", status, 16'h0080);
        ev_ack_slot = 1'b1; ack_nack = 1'b0; step(); ev_ack_slot = 1'b0;
        check("R6 ack", status, 16'h0000);
        ev_ack_slot = 1'b1; ack_nack = 1'b1; step(); ev_ack_slot = 1'b0; ack_nack = 1'b0;
        sw_write(16'h0000);
        check("R6 sw clear", status, 16'h0000);
        sw_write(16'h0080);
        check("R6 sw set ignored", status, 16'h0000);
    endtask

    task automatic t_overrun();
        ev_rx_byte = 1'b1; step(); ev_rx_byte = 1'b0;
        check("R7 first byte", status, 16'h0004);
        ev_rx_byte = 1'b1; step(); ev_rx_byte = 1'b0;
        check("R7 second byte overrun", status, 16'h0204);
        rd_buf = 1'b1; step(); rd_buf = 1'b0;
        check("R7 read clears", status, 16'h0004);
        ev_rx_byte = 1'b1; step(); ev_rx_byte = 1'b0;
        ev_rx_byte = 1'b1; rd_buf = 1'b1; step(); ev_rx_byte = 1'b0; rd_buf = 1'b0;
        check("R7 read with byte no overrun", status, 16'h0004);
        ev_rx_byte = 1'b1; step(); ev_rx_byte = 1'b0;
        check("R7 overrun after read-with-byte", status, 16'h0204);
        sw_write(16'h0000);
        check("R7 write 0 ignored", status, 16'h0200);
        rd_buf = 1'b1; step(); rd_buf = 1'b0;
        check("R7 read clears again", status, 16'h0000);
        sw_write(16'h0200);
        check("R7 sw set", status, 16'h0200);
        sw_write(16'h0000, 1'b1);
        check("R7 clear", status, 16'h0000);
    endtask

    task automatic t_stretch();
        stretch_en = 1'b0; ev_stretch = 1'b1; step(); ev_stretch = 1'b0;
        check("R8 disabled request", {status[14:0], scl_hold_low}, 16'h0000);
        stretch_en = 1'b1; ev_stretch = 1'b1; step(); ev_stretch = 1'b0;
        check("R8 grab", status, 16'h0008);
        check("R8 hold out", {15'h0, scl_hold_low}, 16'h1);
        sw_write(16'h0008);
        check("R8 write 1 keeps", {status[14:0], scl_hold_low}, 16'h0011);
        sw_write(16'h0000);
        check("R8 release", {status[14:0], scl_hold_low}, 16'h0000);
        ev_stretch = 1'b1; wr_en = 1'b1; wr_data = 16'h0000;
        step();
        ev_stretch = 1'b0; wr_en = 1'b0;
        check("R9 stretch beats clear", {status[14:0], scl_hold_low}, 16'h0011);
        sw_write(16'h0000);
        stretch_en = 1'b0;
        check("R8 final release", {status[14:0], scl_hold_low}, 16'h0000);
    endtask

    task automatic t_priority();
        ev_timeout = 1'b1; ev_tx_done = 1'b1; wr_en = 1'b1; wr_data = 16'h0000;
        step();
        ev_timeout = 1'b0; ev_tx_done = 1'b0; wr_en = 1'b0;
        check("R9 hw set wins", status, 16'h0012);
        sw_write(16'h0000);
        check("R9 cleared after", status, 16'h0000);
    endtask

    task automatic t_irq();
        irq_en = 16'h0010;
        ev_timeout = 1'b1; step(); ev_timeout = 1'b0;
        check("R11 flag set", status, 16'h0010);
        check("R11 irq lag", {15'h0, irq}, 16'h0);
        step();
        check("R11 irq raised", {15'h0, irq}, 16'h1);
        irq_en = 16'h0001; step();
        check("R11 masked", {15'h0, irq}, 16'h0);
        irq_en = 16'h0400; scl_level = 1'b1; step();
        check("R11 live bit", {15'h0, irq}, 16'h1);
        scl_level = 1'b0; irq_en = 16'h0000;
        sw_write(16'h0000);
        step();
        check("R11 idle", {15'h0, irq}, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        t_bus();
        t_live();
        t_sw_set();
        t_hw_flags();
        t_nack();
        t_overrun();
        t_stretch();
        t_priority();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule